// File: doc/BRIEF.md
# Voltage-ID Power Sequencing Controller

This block is the sequencing state machine for a regulator that feeds two core supply planes and one northbridge plane. When enable is high and bias is good, it reads two strap pins once. It turns them into a start-up voltage code, using either the normal boot table or the fixed-voltage table, and keeps that code in a hold register. It then soft-starts all three planes toward the held code. Power-good goes high once the ramp is reported complete and all planes are in regulation.

After power-good, the processor raises power-ok, and decoded set-VID commands on a valid/plane/code port move individual plane targets. If power-ok drops, every plane is stepped back to the held start-up code, and the straps are not consulted. After that the block waits for power-ok and for fresh commands. Loss of enable or bias turns the block off. All outputs are tri-stated, power-good falls and the hold register is cleared, so the next start reads the straps again.

Voltage codes are 8 bits wide in 12.5 mV steps, and code 0 means the plane is off. The DAC, the serial command decoder and the analog loop are outside this block.

Top module: `vid_seq_ctrl`

## Requirements
- R1: After reset, and while enable is low, tri_req is 1, pgood is 0 and all three plane targets are 0.
- R2: With fixed_mode=0, the straps {strap_clk,strap_dat} select the start-up code 00→88 (1.1 V), 01→80 (1.0 V), 10→72 (0.9 V), 11→64 (0.8 V). One clock after enable and bias are seen high, tri_req is 0 and the targets are still 0. After the second clock, all three targets equal the selected code and ramp_soft is 1.
- R3: With fixed_mode=1, the straps select 00→112 (1.4 V), 01→96 (1.2 V), 10→80 (1.0 V), 11→64 (0.8 V), with the same timing as R2.
- R4: During soft-start, pgood rises one clock after ramp_done and in_reg are both 1 in the same cycle. Either one alone does not raise it. ramp_soft is 1 only during the sample and soft-start phases, and pgood is never 1 while ramp_soft is 1.
- R5: A command with cmd_valid=1 has no effect unless pgood is 1 and pwr_ok is 1.
- R6: An accepted command writes cmd_code into the target chosen by cmd_plane (0=core0, 1=core1, 2=northbridge) one clock later, with ramp_soft at 0 and pgood unchanged.
- R7: A command of code 0 to core0 or core1 switches that plane off while pgood stays 1. A command of code 0 to the northbridge is rejected, and cmd_plane=3 is ignored. pgood never falls while enable and bias stay high.
- R8: When pwr_ok falls in the active phase, all three targets return to the held start-up code one clock later, whatever the straps show. Commands are ignored until ramp_done is seen and pwr_ok is high again. The targets then keep the held code until a new command arrives.
- R9: Enable low or bias_ok low forces tri_req=1, pgood=0 and all targets to 0 one clock later, and clears the held code. The next start re-reads the straps.
- R10: Strap and mode changes after the sampling clock do not alter the targets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Regulator enable, already compared to its threshold |
| bias_ok | input | 1 | Bias supply above its power-on-reset level |
| fixed_mode | input | 1 | 1 selects the fixed-voltage strap table |
| strap_clk | input | 1 | Strap pin, upper bit of the strap code |
| strap_dat | input | 1 | Strap pin, lower bit of the strap code |
| pwr_ok | input | 1 | Processor power-ok flag |
| ramp_done | input | 1 | Reference ramp has reached its target |
| in_reg | input | 1 | All planes report in regulation |
| cmd_valid | input | 1 | Decoded set-VID command present |
| cmd_plane | input | 2 | Command plane: 0 core0, 1 core1, 2 northbridge |
| cmd_code | input | 8 | Command voltage code, 12.5 mV steps |
| tgt_core0 | output | 8 | Core0 plane target code |
| tgt_core1 | output | 8 | Core1 plane target code |
| tgt_nb | output | 8 | Northbridge plane target code |
| ramp_soft | output | 1 | 1 selects the slow soft-start ramp, 0 the on-the-fly slew |
| tri_req | output | 1 | Request to tri-state all drivers |
| pgood | output | 1 | Power-good |

## Verification
The bench goes through every strap pattern in both tables, and in each case changes the straps after sampling. A design that kept following the pins would show moved targets at once, or report the wrong code on a restart. It raises ramp_done and in_reg on their own to catch a power-good that fires early. It also sends commands before power-ok, during the return to the boot code, to the northbridge with code 0 and to plane 3. Letting any of these through would show as a changed target or a dead northbridge plane. Finally it drops enable and bias at different points, and checks that the held code is cleared rather than kept across the restart.

// File: rtl/vid_seq_pkg.sv
package vid_seq_pkg;
  localparam int CODE_W  = 8;
  localparam int NPLANES = 3;
  localparam int PSEL_W  = 2;
  localparam int STEP_UV = 12500;
  localparam int PL_CORE0 = 0;
  localparam int PL_CORE1 = 1;
  localparam int PL_NB    = 2;

  typedef logic [CODE_W-1:0] vcode_t;

  typedef enum logic [2:0] {
    ST_OFF, ST_SAMPLE, ST_SOFT, ST_WAIT_OK, ST_ACTIVE, ST_RETURN
  } seq_state_e;

  // millivolts to a code in STEP_UV microvolt units
  function automatic vcode_t mv_to_code(int mv);
    return vcode_t'((mv * 1000) / STEP_UV);
  endfunction

  // strap pair to start-up code; fixed table or boot table
  function automatic vcode_t strap_decode(logic fixed, logic [1:0] s);
    int mv;
    if (fixed) begin
      case (s)
        2'd0:    mv = 1400;
        2'd1:    mv = 1200;
        2'd2:    mv = 1000;
        default: mv = 800;
      endcase
    end else begin
      mv = 1100 - 100 * int'(s);
    end
    return mv_to_code(mv);
  endfunction

  // plane must exist; northbridge may not be switched off
  function automatic logic cmd_legal(logic [PSEL_W-1:0] p, vcode_t c);
    return (int'(p) < NPLANES) && !(int'(p) == PL_NB && c == '0);
  endfunction
endpackage

// File: rtl/vid_seq_fsm.sv
module vid_seq_fsm
  import vid_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              bias_ok,
  input  logic              pwr_ok,
  input  logic              ramp_done,
  input  logic              in_reg,
  input  logic              cmd_valid,
  input  logic [PSEL_W-1:0] cmd_plane,
  input  vcode_t            cmd_code,
  output logic              ev_kill,
  output logic              ev_sample,
  output logic              ev_load_hold,
  output logic              cmd_acc,
  output logic              pgood,
  output logic              tri_req,
  output logic              ramp_soft
);
  seq_state_e st_q, st_d;
  logic       pgood_q;
  logic       soft_fin;

  assign ev_kill      = !(en && bias_ok);
  assign soft_fin     = (st_q == ST_SOFT) && ramp_done && in_reg;
  assign ev_sample    = !ev_kill && (st_q == ST_OFF);
  assign ev_load_hold = !ev_kill && ((st_q == ST_SAMPLE) ||
                                     (st_q == ST_ACTIVE && !pwr_ok));
  assign cmd_acc      = !ev_kill && (st_q == ST_ACTIVE) && pwr_ok &&
                        cmd_valid && cmd_legal(cmd_plane, cmd_code);

  always_comb begin
    st_d = st_q;
    if (ev_kill) begin
      st_d = ST_OFF;
    end else begin
      case (st_q)
        ST_OFF:     st_d = ST_SAMPLE;
        ST_SAMPLE:  st_d = ST_SOFT;
        ST_SOFT:    if (soft_fin)   st_d = ST_WAIT_OK;
        ST_WAIT_OK: if (pwr_ok)     st_d = ST_ACTIVE;
        ST_ACTIVE:  if (!pwr_ok)    st_d = ST_RETURN;
        ST_RETURN:  if (ramp_done)  st_d = ST_WAIT_OK;
        default:    st_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_OFF;
      pgood_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (ev_kill)       pgood_q <= 1'b0;
      else if (soft_fin) pgood_q <= 1'b1;
    end
  end

  assign pgood     = pgood_q;
  assign tri_req   = (st_q == ST_OFF);
  assign ramp_soft = (st_q == ST_SAMPLE) || (st_q == ST_SOFT);
endmodule

// File: rtl/vid_seq_hold.sv
module vid_seq_hold
  import vid_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       load,
  input  logic       fixed_mode,
  input  logic [1:0] straps,
  output vcode_t     hold_code
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    hold_code <= '0;
    else if (clr)  hold_code <= '0;
    else if (load) hold_code <= strap_decode(fixed_mode, straps);
  end
endmodule

// File: rtl/vid_seq_targets.sv
module vid_seq_targets
  import vid_seq_pkg::*;
#(
  parameter int NPL = NPLANES,
  parameter int W   = CODE_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr,
  input  logic                  ld_hold,
  input  logic [W-1:0]          hold_code,
  input  logic                  wr,
  input  logic [PSEL_W-1:0]     wr_plane,
  input  logic [W-1:0]          wr_code,
  output logic [NPL-1:0][W-1:0] tgt
);
  for (genvar g = 0; g < NPL; g++) begin : g_plane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       tgt[g] <= '0;
      else if (clr)     tgt[g] <= '0;
      else if (ld_hold) tgt[g] <= hold_code;
      else if (wr && (wr_plane == PSEL_W'(g))) tgt[g] <= wr_code;
    end
  end
endmodule

// File: rtl/vid_seq_ctrl.sv
module vid_seq_ctrl
  import vid_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       bias_ok,
  input  logic       fixed_mode,
  input  logic       strap_clk,
  input  logic       strap_dat,
  input  logic       pwr_ok,
  input  logic       ramp_done,
  input  logic       in_reg,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_plane,
  input  logic [7:0] cmd_code,
  output logic [7:0] tgt_core0,
  output logic [7:0] tgt_core1,
  output logic [7:0] tgt_nb,
  output logic       ramp_soft,
  output logic       tri_req,
  output logic       pgood
);
  logic   ev_kill, ev_sample, ev_load_hold, cmd_acc;
  vcode_t hold_code;
  logic [NPLANES-1:0][CODE_W-1:0] tgt;

  vid_seq_fsm u_fsm (
    .clk, .rst_n, .en, .bias_ok, .pwr_ok, .ramp_done, .in_reg,
    .cmd_valid, .cmd_plane, .cmd_code,
    .ev_kill, .ev_sample, .ev_load_hold, .cmd_acc,
    .pgood, .tri_req, .ramp_soft
  );

  vid_seq_hold u_hold (
    .clk, .rst_n, .clr(ev_kill), .load(ev_sample),
    .fixed_mode, .straps({strap_clk, strap_dat}), .hold_code
  );

  vid_seq_targets #(.NPL(NPLANES), .W(CODE_W)) u_tgt (
    .clk, .rst_n, .clr(ev_kill), .ld_hold(ev_load_hold), .hold_code,
    .wr(cmd_acc), .wr_plane(cmd_plane), .wr_code(cmd_code), .tgt
  );

  assign tgt_core0 = tgt[PL_CORE0];
  assign tgt_core1 = tgt[PL_CORE1];
  assign tgt_nb    = tgt[PL_NB];
endmodule

// File: rtl/vid_seq_chk.sv
module vid_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic       bias_ok,
  input logic       pwr_ok,
  input logic [1:0] cmd_plane,
  input logic [7:0] cmd_code,
  input logic [7:0] tgt_core0,
  input logic [7:0] tgt_core1,
  input logic [7:0] tgt_nb,
  input logic       ramp_soft,
  input logic       tri_req,
  input logic       pgood,
  input logic       ev_load_hold,
  input logic       cmd_acc,
  input logic [7:0] hold_code
);
  p_off_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tri_req |-> (!pgood && tgt_core0 == 8'd0 && tgt_core1 == 8'd0 && tgt_nb == 8'd0));

  p_soft_no_good_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ramp_soft |-> !pgood);

  p_cmd_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_acc |-> (pgood && pwr_ok));

  p_cmd_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_acc && cmd_plane == 2'd0) |=> (tgt_core0 == $past(cmd_code)));

  p_nb_alive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pgood |-> (tgt_nb != 8'd0));

  p_pgood_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pgood && en && bias_ok) |=> pgood);

  p_return_boot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_load_hold |=> (tgt_core0 == $past(hold_code) && tgt_core1 == $past(hold_code) &&
                      tgt_nb == $past(hold_code)));

  p_kill_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!en || !bias_ok) |=> (tri_req && !pgood && tgt_nb == 8'd0));
endmodule

bind vid_seq_ctrl vid_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .bias_ok(bias_ok), .pwr_ok(pwr_ok),
  .cmd_plane(cmd_plane), .cmd_code(cmd_code),
  .tgt_core0(tgt_core0), .tgt_core1(tgt_core1), .tgt_nb(tgt_nb),
  .ramp_soft(ramp_soft), .tri_req(tri_req), .pgood(pgood),
  .ev_load_hold(ev_load_hold), .cmd_acc(cmd_acc), .hold_code(hold_code)
);

// File: tb/vid_seq_ctrl_tb.sv
`timescale 1ns/1ps
module vid_seq_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, bias_ok = 1'b1, fixed_mode = 1'b0;
  logic strap_clk = 1'b0, strap_dat = 1'b0;
  logic pwr_ok = 1'b0, ramp_done = 1'b0, in_reg = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_plane = 2'd0;
  logic [7:0] cmd_code = 8'd0;
  logic [7:0] tgt_core0, tgt_core1, tgt_nb;
  logic ramp_soft, tri_req, pgood;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // expected start-up codes, volts / 12.5 mV
  int boot_tab[4]  = '{88, 80, 72, 64};
  int fixed_tab[4] = '{112, 96, 80, 64};

  always #5 clk = ~clk;

  vid_seq_ctrl u_dut (
    .clk, .rst_n, .en, .bias_ok, .fixed_mode, .strap_clk, .strap_dat,
    .pwr_ok, .ramp_done, .in_reg, .cmd_valid, .cmd_plane, .cmd_code,
    .tgt_core0, .tgt_core1, .tgt_nb, .ramp_soft, .tri_req, .pgood
  );

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_all(string req, int exp);
    chk(req, "tgt_core0", tgt_core0, exp);
    chk(req, "tgt_core1", tgt_core1, exp);
    chk(req, "tgt_nb", tgt_nb, exp);
  endtask

  task automatic send(int plane, int code);
    cmd_valid = 1'b1; cmd_plane = 2'(plane); cmd_code = 8'(code);
    tick(1);
    cmd_valid = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; en = 1'b0;
    tick(2);
    chk("R1", "tri_req in reset", tri_req, 1);
    chk("R1", "pgood in reset", pgood, 0);
    rst_n = 1'b1;
    tick(3);
    chk("R1", "tri_req en low", tri_req, 1);
    chk("R1", "pgood en low", pgood, 0);
    chk_all("R1", 0);
  endtask

  // power up and finish soft-start; checks R2/R3/R4/R10
  task automatic t_powerup(bit fx, int s);
    int exp;
    string rq;
    exp = fx ? fixed_tab[s] : boot_tab[s];
    rq  = fx ? "R3" : "R2";
    fixed_mode = fx; {strap_clk, strap_dat} = 2'(s);
    ramp_done = 1'b0; in_reg = 1'b0; pwr_ok = 1'b0;
    en = 1'b1; bias_ok = 1'b1;
    tick(1);
    chk(rq, "tri_req after sample", tri_req, 0);
    chk(rq, "tgt_nb during sample", tgt_nb, 0);
    tick(1);
    chk_all(rq, exp);
    chk(rq, "ramp_soft soft-start", ramp_soft, 1);
    // R10: disturb straps and mode after sampling
    {strap_clk, strap_dat} = ~2'(s); fixed_mode = ~fx;
    ramp_done = 1'b1;
    tick(1);
    chk("R4", "pgood ramp_done alone", pgood, 0);
    ramp_done = 1'b0; in_reg = 1'b1;
    tick(1);
    chk("R4", "pgood in_reg alone", pgood, 0);
    ramp_done = 1'b1;
    tick(1);
    ramp_done = 1'b0;
    chk("R4", "pgood after both", pgood, 1);
    chk("R4", "ramp_soft after soft-start", ramp_soft, 0);
    chk_all("R10", exp);
  endtask

  task automatic t_kill(bit use_bias);
    if (use_bias) bias_ok = 1'b0; else en = 1'b0;
    pwr_ok = 1'b0;
    tick(1);
    chk("R9", "tri_req after loss", tri_req, 1);
    chk("R9", "pgood after loss", pgood, 0);
    chk_all("R9", 0);
    en = 1'b1; bias_ok = 1'b1;
    en = 1'b0;
    tick(1);
  endtask

  task automatic t_cmd_gate;
    send(0, 100);
    chk("R5", "core0 before pwr_ok", tgt_core0, 80);
    pwr_ok = 1'b1;
    tick(1);
    send(0, 100);
    chk("R6", "core0 written", tgt_core0, 100);
    chk("R6", "ramp_soft on-the-fly", ramp_soft, 0);
    send(1, 90);
    chk("R6", "core1 written", tgt_core1, 90);
    send(2, 70);
    chk("R6", "nb written", tgt_nb, 70);
    chk("R6", "pgood through commands", pgood, 1);
  endtask

  task automatic t_off_cmds;
    send(0, 0);
    chk("R7", "core0 off", tgt_core0, 0);
    chk("R7", "pgood core0 off", pgood, 1);
    send(2, 0);
    chk("R7", "nb off rejected", tgt_nb, 70);
    send(3, 50);
    chk("R7", "plane3 core0", tgt_core0, 0);
    chk("R7", "plane3 core1", tgt_core1, 90);
    chk("R7", "plane3 nb", tgt_nb, 70);
  endtask

  task automatic t_return;
    {strap_clk, strap_dat} = 2'b11; fixed_mode = 1'b1;
    pwr_ok = 1'b0;
    tick(1);
    chk_all("R8", 80);
    chk("R8", "pgood on return", pgood, 1);
    send(1, 99);
    chk("R8", "core1 cmd during return", tgt_core1, 80);
    ramp_done = 1'b1;
    tick(1);
    ramp_done = 1'b0;
    pwr_ok = 1'b1;
    tick(2);
    chk_all("R8", 80);
    send(1, 99);
    chk("R8", "core1 new cmd after reassert", tgt_core1, 99);
  endtask

  initial begin
    t_reset();
    for (int s = 0; s < 4; s++) begin
      t_powerup(1'b0, s);
      t_kill(1'b0);
    end
    for (int s = 0; s < 4; s++) begin
      t_powerup(1'b1, s);
      t_kill(1'b1);
    end
    t_powerup(1'b0, 1);
    t_cmd_gate();
    t_off_cmds();
    t_return();
    t_kill(1'b1);
    t_powerup(1'b0, 3);   // R9 restart re-reads straps
    t_kill(1'b0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule